// File: doc/BRIEF.md
# Stream-Buffer Prefetch Unit

This block sits beside a cache and watches its demand traffic. For each demand request it takes the block address and the cache's own hit result. It then looks the address up in a set of stream buffers. Each buffer tracks a run of consecutive block addresses that have been, or are being, fetched ahead of use. The unit reports whether any buffer held the block. It keeps the matching buffer one run ahead of the demand stream by issuing block-read prefetches to the next level. When neither the cache nor any buffer holds the block, it takes over the least recently used buffer for a new run. The block tracks addresses only. It carries no data, and because its contents are never dirty, it never produces a writeback.

Every buffer is a circular queue of `M` block addresses. A head pointer marks the lowest address in the queue, and there is a single valid flag for the whole buffer. Consuming entries moves the head pointer forward and rewrites only the slots that were freed, so no entry is ever shifted. Prefetches leave one per cycle on a ready/valid channel, and each one is marked as a prefetch. While a burst is still outstanding, the unit holds off new demand requests. Setting the buffer count to zero removes the search and allocation logic. In that case every request is accepted, and nothing is ever prefetched.

Top module: `sbpf_top`

## Requirements
- R1: After reset, no buffer is valid, `req_ready` is 1, `pf_valid` and `rsp_valid` are 0, and `pf_count` is 0.
- R2: A request that misses in the cache and in every buffer reloads the least recently used buffer with blocks X+1 to X+M. The unit issues prefetches for X+1, X+2, ... X+M in ascending order, and the first one is presented in the cycle after acceptance.
- R3: A request is looked up in all M entries of every valid buffer, not only at the head. `rsp_valid` pulses in the cycle after acceptance, and `rsp_sb_hit` then gives the lookup result.
- R4: When a request for block X hits at distance k from the head of a buffer, the k+1 entries up to and including X are retired. The unit prefetches the blocks after the old tail, which are head+M through X+M, in ascending order. The buffer then covers X+1 to X+M.
- R5: A buffer hit advances the buffer in the same way whether the cache hit or missed.
- R6: A request that hits in the cache and misses in every buffer issues no prefetch and changes no buffer and no recency order.
- R7: A buffer that is allocated or advanced becomes the most recently used buffer. Allocation always takes the least recently used buffer.
- R8: When several buffers hold block X, only the most recently used of them advances. The other buffers keep their contents.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_blk` holds its value. One prefetch is transferred per cycle in which both are 1.
- R10: `req_ready` is 0 while any prefetch of the current burst is still untransferred. A request presented then is not accepted and produces no `rsp_valid`.
- R11: `pf_count` increases by exactly one for each prefetch transfer and is otherwise unchanged.
- R12: `pf_is_prefetch` is 1 whenever `pf_valid` is 1.
- R13: Block addresses are modulo 2^BLK_W. A run that starts near the top of the address range wraps through zero, both in the prefetches issued and in later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Demand request present |
| req_ready | output | 1 | Unit can accept a demand request |
| req_blk | input | BLK_W | Block address of the demand request |
| req_cache_hit | input | 1 | The cache hit on this request |
| rsp_valid | output | 1 | Lookup result valid (one cycle after acceptance) |
| rsp_sb_hit | output | 1 | Some buffer held the requested block |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Next level takes the prefetch |
| pf_blk | output | BLK_W | Block address to prefetch |
| pf_is_prefetch | output | 1 | Marks the read as a prefetch for the next level |
| pf_count | output | CNT_W | Number of prefetches transferred since reset |

## Verification
The hardest case to reach from the ports is a request that hits in two buffers at once with different recency. That case is the only place where picking the wrong buffer shows up. The stimulus builds it by missing at X and then at X-2. This leaves two overlapping runs, with the newer one most recently used. A request then goes to a block they share. The number of prefetches that follow, and their addresses, show which buffer advanced. Eviction order is reached in a similar way. All buffers are filled with distinct runs, one more run is forced in, and a later request to the oldest run must miss.

// File: rtl/sbpf_pkg.sv
// Package for the stream-buffer prefetch unit.
// Holds the small helpers that the buffer and top modules share.
// Assumes every ring length passed in is at least 1.
package sbpf_pkg;

    // Ring distance from slot 'from' forward to slot 'to' in a ring of m slots.
    function automatic int ring_dist(input int from, input int to, input int m);
        if (to >= from)
            return to - from;
        else
            return to + m - from;
    endfunction

    // Bit width needed to index n items; never less than one bit.
    function automatic int idx_width(input int n);
        if (n <= 2)
            return 1;
        else
            return $clog2(n);
    endfunction

endpackage

// File: rtl/sbpf_stream.sv
// One stream buffer: a circular queue of M consecutive block addresses.
// It holds one valid flag for the whole queue and a head pointer that marks
// the lowest address. The lookup is combinational over every slot. An
// advance rewrites only the freed slots (each moves up by M) and moves the
// head, so nothing is shifted.
// Assumes alloc_en and adv_en are never both 1, and that adv_en only comes
// in a cycle where this buffer reports hit for look_blk.
module sbpf_stream
    import sbpf_pkg::*;
#(
    parameter int M     = 4,
    parameter int BLK_W = 26,
    parameter int PW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] look_blk,
    input  logic             alloc_en,
    input  logic             adv_en,
    output logic             valid,
    output logic             hit,
    output logic [PW-1:0]    hit_pos
);

    localparam logic [BLK_W-1:0] RUN_LEN = BLK_W'(M);

    logic [BLK_W-1:0] ent [M];
    logic [PW-1:0]    head;
    logic [M-1:0]     drop;
    logic [PW-1:0]    nxt_head;

    assign valid = vld_q;
    logic vld_q;

    // Search every slot and report the hit distance from the head.
    always_comb begin
        hit     = 1'b0;
        hit_pos = '0;
        for (int s = 0; s < M; s++) begin
            if (vld_q && ent[s] == look_blk) begin
                hit     = 1'b1;
                hit_pos = PW'(ring_dist(int'(head), s, M));
            end
        end
    end

    // Mark the slots retired by an advance and work out the new head.
    always_comb begin
        int nh;
        for (int s = 0; s < M; s++)
            drop[s] = ring_dist(int'(head), s, M) <= int'(hit_pos);
        nh = int'(head) + int'(hit_pos) + 1;
        if (nh >= M)
            nh = nh - M;
        nxt_head = PW'(nh);
    end

    // Valid flag and head pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            head  <= '0;
        end else if (alloc_en) begin
            vld_q <= 1'b1;
            head  <= '0;
        end else if (adv_en) begin
            head  <= nxt_head;
        end
    end

    // Slot contents: a fresh run on allocation, freed slots move up by M on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < M; s++)
                ent[s] <= '0;
        end else if (alloc_en) begin
            for (int s = 0; s < M; s++)
                ent[s] <= look_blk + BLK_W'(s + 1);
        end else if (adv_en) begin
            for (int s = 0; s < M; s++)
                if (drop[s])
                    ent[s] <= ent[s] + RUN_LEN;
        end
    end

endmodule

// File: rtl/sbpf_lru.sv
// Recency ranks over N whole buffers. Rank 0 is the most recent and rank
// N-1 the least. After reset buffer i has rank i, so the ranks always form
// a permutation. A touch moves one buffer to rank 0 and ages every buffer
// that ranked above it.
// Assumes touch_idx < N.
module sbpf_lru #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] rank [N]
);

    logic [IW-1:0] rank_q [N];
    logic [IW-1:0] touched_rank;

    assign rank = rank_q;

    // Rank the touched buffer holds before the update.
    always_comb begin
        touched_rank = '0;
        for (int i = 0; i < N; i++)
            if (touch_idx == IW'(i))
                touched_rank = rank_q[i];
    end

    // Rank update on a touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                rank_q[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (touch_idx == IW'(i))
                    rank_q[i] <= '0;
                else if (rank_q[i] < touched_rank)
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sbpf_issue.sv
// Prefetch issue sequencer. It is loaded with a start block and a count,
// then presents ascending block addresses one per handshake. It also keeps
// a count of transferred prefetches.
// Assumes start_en is only raised while busy is 0.
module sbpf_issue #(
    parameter int BLK_W = 26,
    parameter int CW    = 3,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_en,
    input  logic [BLK_W-1:0] start_blk,
    input  logic [CW-1:0]    start_cnt,
    output logic             busy,
    output logic             pf_valid,
    input  logic             pf_ready,
    output logic [BLK_W-1:0] pf_blk,
    output logic [CNT_W-1:0] pf_count
);

    logic [CW-1:0]    remain;
    logic [BLK_W-1:0] cur_blk;
    logic             xfer;

    assign pf_valid = remain != '0;
    assign busy     = pf_valid;
    assign pf_blk   = cur_blk;
    assign xfer     = pf_valid && pf_ready;

    // Load a burst or step through it on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            cur_blk <= '0;
        end else if (start_en) begin
            remain  <= start_cnt;
            cur_blk <= start_blk;
        end else if (xfer) begin
            remain  <= remain - 1'b1;
            cur_blk <= cur_blk + 1'b1;
        end
    end

    // Running count of transferred prefetches.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pf_count <= '0;
        else if (xfer)
            pf_count <= pf_count + 1'b1;
    end

endmodule

// File: rtl/sbpf_top.sv
// Stream-buffer prefetch unit top. For each accepted demand request it
// searches all buffers, picks the most recent hitting buffer (or the least
// recent buffer on a full miss), updates that buffer and the recency order,
// and starts a prefetch burst. A request is accepted only when no burst is
// outstanding. N = 0 removes the buffers altogether.
// Assumes req_blk and req_cache_hit are stable while req_valid waits.
module sbpf_top
    import sbpf_pkg::*;
#(
    parameter int N     = 4,
    parameter int M     = 4,
    parameter int BLK_W = 26,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             req_cache_hit,
    output logic             rsp_valid,
    output logic             rsp_sb_hit,
    output logic             pf_valid,
    input  logic             pf_ready,
    output logic [BLK_W-1:0] pf_blk,
    output logic             pf_is_prefetch,
    output logic [CNT_W-1:0] pf_count
);

    localparam int PW = idx_width(M);
    localparam int CW = $clog2(M + 1);
    localparam int NB = (N > 0) ? N : 1;
    localparam int IW = idx_width(NB);

    logic             acc;
    logic             busy;
    logic             any_hit;
    logic             start_en;
    logic [BLK_W-1:0] start_blk;
    logic [CW-1:0]    start_cnt;

    assign req_ready      = !busy;
    assign acc            = req_valid && req_ready;
    assign pf_is_prefetch = 1'b1;

    generate
        if (N == 0) begin : g_off
            assign any_hit   = 1'b0;
            assign start_en  = 1'b0;
            assign start_blk = '0;
            assign start_cnt = '0;
        end else begin : g_on
            logic [N-1:0]  b_valid;
            logic [N-1:0]  b_hit;
            logic [PW-1:0] b_pos [N];
            logic [N-1:0]  b_alloc;
            logic [N-1:0]  b_adv;
            logic [IW-1:0] rank [N];
            logic          win_found;
            logic [IW-1:0] win_idx;
            logic [IW-1:0] win_rank;
            logic [PW-1:0] win_pos;
            logic [IW-1:0] vic_idx;
            logic          touch_en;
            logic [IW-1:0] touch_idx;

            for (genvar i = 0; i < N; i++) begin : g_buf
                sbpf_stream #(.M(M), .BLK_W(BLK_W), .PW(PW)) u_buf (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .look_blk (req_blk),
                    .alloc_en (b_alloc[i]),
                    .adv_en   (b_adv[i]),
                    .valid    (b_valid[i]),
                    .hit      (b_hit[i]),
                    .hit_pos  (b_pos[i])
                );
            end

            sbpf_lru #(.N(N), .IW(IW)) u_lru (
                .clk       (clk),
                .rst_n     (rst_n),
                .touch_en  (touch_en),
                .touch_idx (touch_idx),
                .rank      (rank)
            );

            // Most recent hitting buffer, taking the lowest rank among the hits.
            always_comb begin
                win_found = 1'b0;
                win_idx   = '0;
                win_rank  = '0;
                win_pos   = '0;
                for (int i = 0; i < N; i++) begin
                    if (b_hit[i] && (!win_found || rank[i] < win_rank)) begin
                        win_found = 1'b1;
                        win_idx   = IW'(i);
                        win_rank  = rank[i];
                        win_pos   = b_pos[i];
                    end
                end
            end

            // Least recent buffer, the one holding rank N-1.
            always_comb begin
                vic_idx = '0;
                for (int i = 0; i < N; i++)
                    if (rank[i] == IW'(N - 1))
                        vic_idx = IW'(i);
            end

            // Buffer control strobes and recency touch for the accepted request.
            always_comb begin
                for (int i = 0; i < N; i++) begin
                    b_adv[i]   = acc && win_found && (win_idx == IW'(i));
                    b_alloc[i] = acc && !win_found && !req_cache_hit && (vic_idx == IW'(i));
                end
                touch_en  = acc && (win_found || !req_cache_hit);
                touch_idx = win_found ? win_idx : vic_idx;
            end

            // Burst to start: the run after the old tail, or a whole new run.
            always_comb begin
                start_en = touch_en;
                if (win_found) begin
                    start_cnt = CW'(win_pos) + 1'b1;
                    start_blk = req_blk + BLK_W'(M) - BLK_W'(win_pos);
                end else begin
                    start_cnt = CW'(M);
                    start_blk = req_blk + 1'b1;
                end
            end

            assign any_hit = win_found;

            logic unused_valid;
            assign unused_valid = ^b_valid;
        end
    endgenerate

    sbpf_issue #(.BLK_W(BLK_W), .CW(CW), .CNT_W(CNT_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_en  (start_en),
        .start_blk (start_blk),
        .start_cnt (start_cnt),
        .busy      (busy),
        .pf_valid  (pf_valid),
        .pf_ready  (pf_ready),
        .pf_blk    (pf_blk),
        .pf_count  (pf_count)
    );

    // Lookup result, registered one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_sb_hit <= 1'b0;
        end else begin
            rsp_valid  <= acc;
            rsp_sb_hit <= acc && any_hit;
        end
    end

endmodule

// File: rtl/sbpf_checker.sv
// Protocol and behaviour properties for sbpf_top, attached with bind.
// It watches only the top-level ports.
module sbpf_checker #(
    parameter int N     = 4,
    parameter int BLK_W = 26,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [BLK_W-1:0] req_blk,
    input logic             req_cache_hit,
    input logic             rsp_valid,
    input logic             rsp_sb_hit,
    input logic             pf_valid,
    input logic             pf_ready,
    input logic [BLK_W-1:0] pf_blk,
    input logic [CNT_W-1:0] pf_count
);

    localparam logic [BLK_W-1:0] ONE = 1;

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_blk)));

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !rsp_valid);

    p_count_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready) |=> (pf_count == $past(pf_count) + 1'b1));

    p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pf_valid && pf_ready) |=> $stable(pf_count));

    p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready) |=> (!pf_valid || pf_blk == $past(pf_blk) + ONE));

    p_alloc_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((N > 0) && rsp_valid && !rsp_sb_hit && !$past(req_cache_hit))
        |-> (pf_valid && pf_blk == $past(req_blk) + ONE));

    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_sb_hit && $past(req_cache_hit)) |-> !pf_valid);

    p_rsp_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sb_hit |-> rsp_valid);

endmodule

bind sbpf_top sbpf_checker #(.N(N), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_blk       (req_blk),
    .req_cache_hit (req_cache_hit),
    .rsp_valid     (rsp_valid),
    .rsp_sb_hit    (rsp_sb_hit),
    .pf_valid      (pf_valid),
    .pf_ready      (pf_ready),
    .pf_blk        (pf_blk),
    .pf_count      (pf_count)
);

// File: tb/sbpf_top_test.sv
`timescale 1ns/1ps
module sbpf_top_test;

    localparam int N     = 4;
    localparam int M     = 4;
    localparam int BLK_W = 26;
    localparam int CNT_W = 32;
    localparam int unsigned MASK = (32'd1 << BLK_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [BLK_W-1:0] req_blk = '0;
    logic             req_cache_hit = 1'b0;
    logic             rsp_valid;
    logic             rsp_sb_hit;
    logic             pf_valid;
    logic             pf_ready = 1'b1;
    logic [BLK_W-1:0] pf_blk;
    logic             pf_is_prefetch;
    logic [CNT_W-1:0] pf_count;

    sbpf_top #(.N(N), .M(M), .BLK_W(BLK_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_blk(req_blk), .req_cache_hit(req_cache_hit), .rsp_valid(rsp_valid),
        .rsp_sb_hit(rsp_sb_hit), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_blk(pf_blk), .pf_is_prefetch(pf_is_prefetch), .pf_count(pf_count)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string cur_tag = "R1";
    bit rnd_ready = 1'b0;

    // Reference model: buffers as (valid, lowest block), recency as a queue of indices.
    bit          mval [N];
    int unsigned mbase [N];
    int          order [$];
    int unsigned pend [$];
    int unsigned mcount;
    bit          e_rv, e_rh, macc;
    int          w, k;

    task automatic touch(input int b);
        for (int j = 0; j < order.size(); j++)
            if (order[j] == b) begin
                order.delete(j);
                break;
            end
        order.push_front(b);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mval[i] = 0;
                mbase[i] = 0;
            end
            order.delete();
            for (int i = 0; i < N; i++) order.push_back(i);
            pend.delete();
            mcount = 0;
            e_rv = 0;
            e_rh = 0;
        end else begin
            macc = req_valid && (pend.size() == 0);
            if (pf_ready && pend.size() > 0) begin
                void'(pend.pop_front());
                mcount++;
            end
            e_rv = macc;
            e_rh = 0;
            if (macc) begin
                w = -1;
                for (int j = 0; j < order.size(); j++)
                    if (w < 0 && mval[order[j]] &&
                        (((int'(req_blk) - mbase[order[j]]) & MASK) < M))
                        w = order[j];
                if (w >= 0) begin
                    e_rh = 1;
                    k = ((int'(req_blk) - mbase[w]) & MASK);
                    for (int q = 0; q <= k; q++)
                        pend.push_back((mbase[w] + M + q) & MASK);
                    mbase[w] = (int'(req_blk) + 1) & MASK;
                    touch(w);
                end else if (!req_cache_hit) begin
                    w = order[order.size()-1];
                    mval[w] = 1;
                    mbase[w] = (int'(req_blk) + 1) & MASK;
                    for (int q = 0; q < M; q++)
                        pend.push_back((int'(req_blk) + 1 + q) & MASK);
                    touch(w);
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R10", "req_ready", 64'(req_ready), 64'(pend.size() == 0));
        chk(cur_tag, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        if (e_rv) chk(cur_tag, "rsp_sb_hit", 64'(rsp_sb_hit), 64'(e_rh));
        chk(cur_tag, "pf_valid", 64'(pf_valid), 64'(pend.size() != 0));
        if (pend.size() != 0) begin
            chk(cur_tag, "pf_blk", 64'(pf_blk), 64'(pend[0]));
            chk("R12", "pf_is_prefetch", 64'(pf_is_prefetch), 64'd1);
        end
        chk("R11", "pf_count", 64'(pf_count), 64'(mcount));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
        if (rnd_ready) pf_ready = ($urandom % 4) != 0;
    endtask

    task automatic send(input int unsigned blk, input bit ch);
        bit rdy;
        req_valid = 1'b1;
        req_blk = BLK_W'(blk);
        req_cache_hit = ch;
        do begin
            rdy = req_ready;
            step();
        end while (!rdy);
        req_valid = 1'b0;
    endtask

    task automatic idle();
        while (!req_ready || pf_valid) step();
        step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        compare();
        rst_n = 1'b1;
        step();
        step();

        cur_tag = "R2";           // full miss: new run X+1..X+M
        send(100, 0); idle();
        cur_tag = "R3";           // hit deep inside the queue, not at the head
        send(103, 0); idle();
        cur_tag = "R5";           // cache hit keeps the buffer in step
        send(104, 1); idle();
        cur_tag = "R6";           // cache hit, no buffer hit: nothing happens
        send(500, 1); idle();
        cur_tag = "R4";           // state unchanged by R6 request: still hits
        send(105, 0); idle();

        cur_tag = "R9";           // back-pressure on the prefetch channel
        pf_ready = 1'b0;
        send(1000, 0);
        repeat (3) step();
        pf_ready = 1'b1; step();
        pf_ready = 1'b0; step(); step();
        pf_ready = 1'b1; idle();

        cur_tag = "R10";          // request waits while a burst is outstanding
        pf_ready = 1'b0;
        send(7000, 0);
        fork
            send(7100, 0);
            begin
                repeat (5) @(negedge clk);
                pf_ready = 1'b1;
            end
        join
        idle();

        cur_tag = "R7";           // eviction of the least recently used run
        send(2000, 0); idle();
        send(3000, 0); idle();
        send(4000, 0); idle();
        send(106, 0); idle();
        send(1001, 0); idle();

        cur_tag = "R8";           // overlapping runs: only the most recent advances
        send(5000, 0); idle();
        send(4998, 0); idle();
        send(5001, 0); idle();
        send(5002, 0); idle();

        cur_tag = "R13";          // wrap through zero
        send(MASK - 1, 0); idle();
        send(1, 0); idle();

        cur_tag = "R4";           // mixed traffic with random back-pressure
        rnd_ready = 1'b1;
        for (int n = 0; n < 400; n++)
            send(9000 + ($urandom % 24), ($urandom % 3) == 0);
        rnd_ready = 1'b0;
        pf_ready = 1'b1;
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule